// File: doc/BRIEF.md
# System-Side Frame and Multiframe Timer

This block produces the system-side timing for a backplane that carries T1 or E1 PCM data. A counter chain runs from the system clock. It aligns to the rising edge of the system frame sync and free-runs between sync edges. From that chain the block derives:

- the bit position within the frame and the frame index within the multiframe;
- the channel (slot) index;
- a framing-bit flag, a channel clock and a bit-8 (LSB) strobe;
- an idle-slot flag for E1 slots beyond the 24 voice channels;
- a stretched multiframe pulse that marks the instants at which signaling may be updated.

Two selects set the format, and both are expected to change only while the block is held in reset. The rate select chooses between a 193-bit frame, which leads with a framing bit, and a 256-bit frame of 32 eight-bit slots. The multiframe select chooses between 12 and 24 frames per multiframe. A sync edge that arrives anywhere other than the last bit of a frame still realigns the chain, and it raises a one-cycle resync flag so that the surrounding logic can see that the sync has moved.

Top module: `sys_frame_timer`

## Requirements
- R1: While rst_ni is low, the outputs show bit 0 of frame 0: bit_cnt_o=0, frame_cnt_o=0, slot_o=0, mf_pulse_o=0, resync_o=0 and idle_slot_o=0. With rate_sel_i=0, fbit_o=1 and chan_clk_o=0. With rate_sel_i=1, fbit_o=0 and chan_clk_o=1. bit8_o=0 in both cases.
- R2: When a clock edge sees fsync_i high after it was low at the previous edge, bit_cnt_o is 0 in the next cycle and frame_cnt_o advances by one, wrapping at the multiframe length.
- R3: With no sync edge, bit_cnt_o counts up by one per cycle. It wraps to 0 after 192 when rate_sel_i=0 (193-bit frame) and after 255 when rate_sel_i=1 (256-bit frame). frame_cnt_o advances on each wrap.
- R4: frame_cnt_o runs from 0 to 11 when mf_long_i=0 and from 0 to 23 when mf_long_i=1, then returns to 0.
- R5: With rate_sel_i=0, bit 0 is the framing bit: fbit_o=1 and slot_o=0. Bits 1+8n to 8+8n belong to slot n (0 to 23). With rate_sel_i=1, bits 8n to 8n+7 belong to slot n (0 to 31) and fbit_o stays 0.
- R6: chan_clk_o is high for the first four bits of each slot and low for the last four. It is also low during the framing bit, so it rises on each slot boundary.
- R7: bit8_o is high only on the eighth (last) bit of each slot and never during the framing bit.
- R8: idle_slot_o is high only when rate_sel_i=1 and slot_o is 24 or greater, which is bits 192 to 255.
- R9: mf_pulse_o goes high in the cycle where frame_cnt_o wraps to 0 with bit_cnt_o=0. It stays high for exactly 65 cycles. The counters leaving reset do not start a pulse.
- R10: resync_o is high for one cycle, the cycle in which bit_cnt_o shows 0, when a sync edge arrived while bit_cnt_o was not at the last bit of the frame. A sync edge on the last bit leaves resync_o low.
- R11: Holding fsync_i high counts as a single edge: the counters keep running and no further realignment or resync occurs until fsync_i has been seen low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | System frame sync; a rising edge starts a frame |
| rate_sel_i | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| mf_long_i | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| bit_cnt_o | output | 8 | Bit position within the frame |
| frame_cnt_o | output | 5 | Frame index within the multiframe |
| slot_o | output | 5 | Channel slot index, 0-based |
| fbit_o | output | 1 | Framing-bit time (193-bit frame only) |
| chan_clk_o | output | 1 | Channel clock, rises on slot boundaries |
| bit8_o | output | 1 | LSB (bit 8) strobe of each slot |
| idle_slot_o | output | 1 | Slot above the 24 voice channels in a 256-bit frame |
| mf_pulse_o | output | 1 | Stretched multiframe pulse, 65 cycles |
| resync_o | output | 1 | Sync edge arrived at an unexpected bit position |

## Verification
Every output depends on a single register stage behind the sync edge detector. A sync edge sampled at a clock edge therefore shows up in bit_cnt_o, frame_cnt_o, resync_o, mf_pulse_o and all the decoded strobes in the cycle that follows that edge. When no sync edge arrives, the outputs move on by exactly one bit per cycle.

The driver sets fsync_i on the falling edge. It then pushes the outputs expected after the next rising edge, computed from the frame layout, the multiframe lengths and the 65-cycle hold. The monitor pops that entry 2 ns after the rising edge, so each comparison lands on the first cycle in which the new value is due. The monitor also measures every multiframe pulse from rise to fall. Directed checks made right after the sync edges cover realignment, resync and a sync held high.

// File: rtl/sys_frame_timer_pkg.sv
package sys_frame_timer_pkg;

  typedef enum logic {
    RATE_T1 = 1'b0,
    RATE_E1 = 1'b1
  } rate_e;

  typedef enum logic {
    MF_SHORT_SEL = 1'b0,
    MF_LONG_SEL  = 1'b1
  } mf_len_e;

endpackage

// File: rtl/sft_sync_edge.sv
module sft_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);

  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;

endmodule

// File: rtl/sft_frame_cnt.sv
module sft_frame_cnt
  import sys_frame_timer_pkg::*;
#(
  parameter int T1_BITS  = 193,
  parameter int E1_BITS  = 256,
  parameter int MF_SHORT = 12,
  parameter int MF_LONG  = 24,
  parameter int BIT_W    = 8,
  parameter int FRM_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  rate_e            rate_i,
  input  mf_len_e          mf_len_i,
  output logic [BIT_W-1:0] bit_o,
  output logic [FRM_W-1:0] frm_o,
  output logic             mf_start_o,
  output logic             resync_o
);

  logic [BIT_W-1:0] bit_q, bit_last;
  logic [FRM_W-1:0] frm_q, frm_last;
  logic             resync_q, boundary, mf_wrap;

  always_comb begin
    bit_last = (rate_i == RATE_E1) ? BIT_W'(E1_BITS - 1) : BIT_W'(T1_BITS - 1);
    frm_last = (mf_len_i == MF_LONG_SEL) ? FRM_W'(MF_LONG - 1) : FRM_W'(MF_SHORT - 1);
    // >= keeps the chain bounded if a select moves mid-frame
    boundary = rise_i || (bit_q >= bit_last);
    mf_wrap  = boundary && (frm_q >= frm_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      frm_q    <= '0;
      resync_q <= 1'b0;
    end else begin
      resync_q <= rise_i && (bit_q != bit_last);
      if (boundary) begin
        bit_q <= '0;
        frm_q <= mf_wrap ? '0 : frm_q + FRM_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  assign bit_o      = bit_q;
  assign frm_o      = frm_q;
  assign mf_start_o = mf_wrap;
  assign resync_o   = resync_q;

  a_r2_sync_realigns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (bit_q == '0));

  a_r10_resync_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_q |-> $past(rise_i));

  a_r4_mf_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_o |=> (frm_q == '0));

endmodule

// File: rtl/sft_slot_decode.sv
module sft_slot_decode
  import sys_frame_timer_pkg::*;
#(
  parameter int BIT_W      = 8,
  parameter int SUB_W      = 3,
  parameter int LIVE_SLOTS = 24,
  localparam int SLOT_W    = BIT_W - SUB_W
) (
  input  rate_e             rate_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              fbit_o,
  output logic              chan_clk_o,
  output logic              bit8_o,
  output logic              idle_o
);

  logic [BIT_W-1:0] pos;
  logic [SUB_W-1:0] sub;
  logic             is_fbit;

  always_comb begin
    is_fbit = (rate_i == RATE_T1) && (bit_i == '0);
    // T1 slots sit one bit later, behind the framing bit
    pos     = (rate_i == RATE_T1) ? bit_i - BIT_W'(1) : bit_i;
    sub     = pos[SUB_W-1:0];
    slot_o  = is_fbit ? '0 : pos[BIT_W-1:SUB_W];
    fbit_o     = is_fbit;
    chan_clk_o = !is_fbit && !sub[SUB_W-1];
    bit8_o     = !is_fbit && (sub == '1);
    idle_o     = (rate_i == RATE_E1) && (slot_o >= SLOT_W'(LIVE_SLOTS));
  end

endmodule

// File: rtl/sft_mf_stretch.sv
module sft_mf_stretch #(
  parameter int HOLD    = 65,
  localparam int HOLD_W = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);

  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (start_i)       hold_q <= HOLD_W'(HOLD);
    else if (hold_q != '0)  hold_q <= hold_q - HOLD_W'(1);
  end

  assign pulse_o = (hold_q != '0);

  a_r9_pulse_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(start_i));

endmodule

// File: rtl/sys_frame_timer.sv
module sys_frame_timer
  import sys_frame_timer_pkg::*;
#(
  parameter int T1_FRAME_BITS = 193,
  parameter int E1_SLOTS      = 32,
  parameter int SLOT_BITS     = 8,
  parameter int LIVE_SLOTS    = 24,
  parameter int MF_SHORT      = 12,
  parameter int MF_LONG       = 24,
  parameter int MF_HOLD       = 65,
  localparam int E1_BITS      = E1_SLOTS * SLOT_BITS,
  localparam int BIT_W        = $clog2(E1_BITS),
  localparam int SUB_W        = $clog2(SLOT_BITS),
  localparam int SLOT_W       = BIT_W - SUB_W,
  localparam int FRM_W        = $clog2(MF_LONG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              rate_sel_i,
  input  logic              mf_long_i,
  output logic [BIT_W-1:0]  bit_cnt_o,
  output logic [FRM_W-1:0]  frame_cnt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              fbit_o,
  output logic              chan_clk_o,
  output logic              bit8_o,
  output logic              idle_slot_o,
  output logic              mf_pulse_o,
  output logic              resync_o
);

  rate_e   rate;
  mf_len_e mf_len;
  logic    sync_rise;
  logic    mf_start;

  assign rate   = rate_e'(rate_sel_i);
  assign mf_len = mf_len_e'(mf_long_i);

  sft_sync_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (fsync_i),
    .rise_o (sync_rise)
  );

  sft_frame_cnt #(
    .T1_BITS  (T1_FRAME_BITS),
    .E1_BITS  (E1_BITS),
    .MF_SHORT (MF_SHORT),
    .MF_LONG  (MF_LONG),
    .BIT_W    (BIT_W),
    .FRM_W    (FRM_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (sync_rise),
    .rate_i     (rate),
    .mf_len_i   (mf_len),
    .bit_o      (bit_cnt_o),
    .frm_o      (frame_cnt_o),
    .mf_start_o (mf_start),
    .resync_o   (resync_o)
  );

  sft_slot_decode #(
    .BIT_W      (BIT_W),
    .SUB_W      (SUB_W),
    .LIVE_SLOTS (LIVE_SLOTS)
  ) u_dec (
    .rate_i     (rate),
    .bit_i      (bit_cnt_o),
    .slot_o     (slot_o),
    .fbit_o     (fbit_o),
    .chan_clk_o (chan_clk_o),
    .bit8_o     (bit8_o),
    .idle_o     (idle_slot_o)
  );

  sft_mf_stretch #(
    .HOLD (MF_HOLD)
  ) u_mf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mf_start),
    .pulse_o (mf_pulse_o)
  );

  a_r6_clk_rise_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_clk_o) |-> ($past(bit8_o) || $past(fbit_o) || resync_o));

  a_r7_bit8_then_new_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit8_o |=> (chan_clk_o || fbit_o));

  a_r8_idle_tail_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_slot_o |-> (bit_cnt_o >= BIT_W'(LIVE_SLOTS * SLOT_BITS)));

  a_r9_mf_at_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mf_pulse_o) |-> (bit_cnt_o == '0 && frame_cnt_o == '0));

endmodule

// File: tb/sys_frame_timer_tb.sv
module sys_frame_timer_tb;

  typedef struct {
    int bitc;
    int frm;
    int slot;
    int fbit;
    int cclk;
    int b8;
    int idle;
    int mf;
    int res;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       rate_sel = 1'b0;
  logic       mf_long = 1'b0;
  logic [7:0] bit_cnt;
  logic [4:0] frame_cnt;
  logic [4:0] slot;
  logic       fbit, chan_clk, bit8, idle_slot, mf_pulse, resync;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_bit, m_frm, m_hold;
  logic m_fsq;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sys_frame_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fsync_i     (fsync),
    .rate_sel_i  (rate_sel),
    .mf_long_i   (mf_long),
    .bit_cnt_o   (bit_cnt),
    .frame_cnt_o (frame_cnt),
    .slot_o      (slot),
    .fbit_o      (fbit),
    .chan_clk_o  (chan_clk),
    .bit8_o      (bit8),
    .idle_slot_o (idle_slot),
    .mf_pulse_o  (mf_pulse),
    .resync_o    (resync)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int frame_last();
    return rate_sel ? 255 : 192;
  endfunction

  // Expected outputs for a given bit position, from the frame layout
  function automatic exp_t layout(input int b);
    exp_t e;
    int   p;
    e.bitc = b;
    e.frm  = m_frm;
    e.mf   = (m_hold > 0);
    e.res  = 0;
    if (!rate_sel && b == 0) begin
      e.fbit = 1; e.slot = 0; e.cclk = 0; e.b8 = 0; e.idle = 0;
    end else begin
      p = rate_sel ? b : b - 1;
      e.fbit = 0;
      e.slot = p / 8;
      e.cclk = ((p % 8) < 4);
      e.b8   = ((p % 8) == 7);
      e.idle = rate_sel && (e.slot >= 24);
    end
    return e;
  endfunction

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic tick(input logic fs);
    exp_t e;
    logic rise, bnd, start, res;
    int   flast;
    fsync = fs;
    flast = mf_long ? 23 : 11;
    rise  = fs && !m_fsq;
    m_fsq = fs;
    bnd   = rise || (m_bit == frame_last());
    res   = rise && (m_bit != frame_last());
    start = bnd && (m_frm == flast);
    if (bnd) begin
      m_bit = 0;
      m_frm = start ? 0 : m_frm + 1;
    end else begin
      m_bit = m_bit + 1;
    end
    m_hold = start ? 65 : ((m_hold > 0) ? m_hold - 1 : 0);
    e = layout(m_bit);
    e.res = res;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic r, input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    fsync = 1'b0;
    rate_sel = r;
    mf_long = m;
    q.delete();
    m_bit = 0; m_frm = 0; m_hold = 0; m_fsq = 1'b0;
    #1;
    chk("R1", "reset bit_cnt", bit_cnt, 0);
    chk("R1", "reset frame_cnt", frame_cnt, 0);
    chk("R1", "reset slot", slot, 0);
    chk("R1", "reset mf_pulse", mf_pulse, 0);
    chk("R1", "reset resync", resync, 0);
    chk("R1", "reset idle", idle_slot, 0);
    chk("R1", "reset bit8", bit8, 0);
    chk("R1", "reset fbit", fbit, r ? 0 : 1);
    chk("R1", "reset chan_clk", chan_clk, r ? 1 : 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Frames with a one-cycle sync pulse on the expected last bit
  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      while (m_bit != frame_last()) tick(1'b0);
      tick(1'b1);
      chk("R10", "resync on aligned sync", resync, 0);
      chk("R2", "bit_cnt after aligned sync", bit_cnt, 0);
    end
  endtask

  task automatic early_sync_checks(input int lead);
    int fexp;
    repeat (lead) tick(1'b0);
    fexp = m_frm + 1;
    tick(1'b1);
    chk("R2", "bit_cnt after early sync", bit_cnt, 0);
    chk("R2", "frame_cnt after early sync", frame_cnt, fexp);
    chk("R10", "resync after early sync", resync, 1);
    for (int k = 0; k < 4; k++) tick(1'b1);
    chk("R11", "bit_cnt with sync held high", bit_cnt, 4);
    chk("R11", "resync with sync held high", resync, 0);
    chk("R11", "frame_cnt with sync held high", frame_cnt, fexp);
    tick(1'b0);
  endtask

  // Monitor: compares each expected entry just after the rising edge
  int mf_run = 0;
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!rst_n) begin
      mf_run = 0;
    end else begin
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R3", "bit_cnt", bit_cnt, e.bitc);
        chk("R4", "frame_cnt", frame_cnt, e.frm);
        chk("R5", "slot", slot, e.slot);
        chk("R5", "fbit", fbit, e.fbit);
        chk("R6", "chan_clk", chan_clk, e.cclk);
        chk("R7", "bit8", bit8, e.b8);
        chk("R8", "idle_slot", idle_slot, e.idle);
        chk("R9", "mf_pulse", mf_pulse, e.mf);
        chk("R10", "resync", resync, e.res);
      end
      if (mf_pulse) begin
        mf_run++;
      end else if (mf_run > 0) begin
        chk("R9", "mf pulse width", mf_run, 65);
        mf_run = 0;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // 193-bit frame, 12-frame multiframe
    do_reset(1'b0, 1'b0);
    early_sync_checks(20);
    run_frames(26);
    repeat (400) tick(1'b0);  // free-run wraps without sync

    // 256-bit frame, 24-frame multiframe
    do_reset(1'b1, 1'b1);
    early_sync_checks(10);
    run_frames(50);

    // 193-bit frame, 24-frame multiframe
    do_reset(1'b0, 1'b1);
    early_sync_checks(100);
    run_frames(26);

    // 256-bit frame, 12-frame multiframe, free-running
    do_reset(1'b1, 1'b0);
    repeat (256 * 13 + 80) tick(1'b0);
    early_sync_checks(37);
    run_frames(2);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule